// File: doc/BRIEF.md
# Transmit Buffer Replay Controller

This block sits in a transmit chain between a DMA engine and a digital-to-analog converter. The DMA delivers one packet over an AXI4-Stream input, and that packet is the whole buffer. The block writes it into a local RAM. Once a start condition is met, it plays the stored beats to the converter as a continuous output stream with no tlast. Playback runs once and returns to idle (oneshot), or repeats the buffer with no gap (cyclic).

Three start conditions are available:
- **Automatic:** playback starts when the packet's final beat has been stored.
- **Hardware:** playback starts on a pulse at an external sync input.
- **Software:** playback starts on a request bit that clears itself when playback begins.

A hardware pulse that arrives before the packet is complete cuts the buffer short. Playback covers only the beats stored so far, and the rest of the packet is refused.

A bypass setting turns all of this off and joins the input stream directly to the output. The design has a single clock.

Top module: `tx_offload_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), inReady and outValid are low and swPending is low.
- R2: In idle, inReady stays low and a high initReq moves the block to state code 1 (fill) on the next cycle, where inReady is high.
- R3: Beats accepted in fill are stored in order from RAM entry 0. On playback, every byte whose inKeep bit (bit b qualifies byte lane b, bits 8b+7..8b) was 0 reads as 0x00. The buffer ends at the beat with inLast high, or at the DEPTH-th beat if inLast never comes.
- R4: With syncMode 0 (automatic), the cycle after the final beat is accepted shows state code 3 (play), with outValid high and outData equal to the first stored beat.
- R5: With syncMode 1 (hardware), a completed buffer waits in state code 2 (armed) until syncPulse is high. Play starts the next cycle.
- R6: With syncMode 1, a syncPulse during fill ends the buffer when at least one beat is stored or is accepted in that cycle. Playback then covers only those beats, and inReady is low afterwards. A syncPulse in fill with no beat stored has no effect.
- R7: A one-cycle swStart sets swPending. With syncMode 2 or 3 (software), an armed block with swPending high enters play on the next cycle and clears swPending.
- R8: In play with oneshot low, the beat after the last stored one is stored beat 0, with outValid held high throughout.
- R9: In play with oneshot high, the handshake of the last stored beat returns the block to idle on the next cycle. oneshot is sampled at that beat, so setting it during cyclic play ends the current pass.
- R10: initReq has no effect while in play.
- R11: With bypass high: outValid equals inValid, outData equals inData, inReady equals outReady, all with no delay. The state returns to idle and swPending is cleared one cycle later.
- R12: While outValid is high and outReady is low, outValid stays high and outData does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input stream beat valid |
| inReady | output | 1 | Input stream ready |
| inData | input | DATA_W | Input stream payload |
| inKeep | input | DATA_W/8 | Byte qualifiers of the input beat |
| inLast | input | 1 | Final beat of the packet |
| initReq | input | 1 | Source requests to load a new buffer |
| syncPulse | input | 1 | External start pulse |
| swStart | input | 1 | Software start request (one-cycle write strobe) |
| syncMode | input | 2 | 0 automatic, 1 hardware, 2 or 3 software |
| oneshot | input | 1 | 1 play once, 0 repeat |
| bypass | input | 1 | Route input straight to output |
| outValid | output | 1 | Output stream valid |
| outReady | input | 1 | Output stream ready |
| outData | output | DATA_W | Output stream payload |
| stateCode | output | 2 | 0 idle, 1 fill, 2 armed, 3 play |
| swPending | output | 1 | Software start request pending |

## Verification
Every control decision is registered once, and the output stream reads RAM combinationally. So each state change, and the first playback beat, shows up one cycle after the edge that sees its cause. This covers init, the final stored beat, the sync pulse, and the oneshot end. A software request needs two cycles: one edge to set swPending and the next to consume it. Bypass is the one exception, since its outputs follow the inputs within the same cycle. The bench drives and samples one time unit after each rising edge, and checks each result in the cycle counted above.

// File: rtl/tx_offload_pkg.sv
package tx_offload_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_ARMED = 2'd2,
    ST_PLAY  = 2'd3
  } ctrlState_t;

  localparam logic [1:0] MODE_AUTO = 2'd0;
  localparam logic [1:0] MODE_HW   = 2'd1;

  typedef struct packed {
    logic wrEn;
    logic wrClear;
    logic lenLatch;
    logic rdStep;
    logic rdClear;
  } storeCtl_t;

endpackage

// File: rtl/tx_offload_store.sv
module tx_offload_store
  import tx_offload_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCtl_t         ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W/8-1:0] wrKeep,
  output logic [DATA_W-1:0] rdData,
  output logic              wrFull,
  output logic              wrEmpty,
  output logic              rdAtEnd
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int KEEP_W = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] maskedData;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [CNT_W-1:0]  storedLen;

  for (genvar b = 0; b < KEEP_W; b++) begin : g_lane
    assign maskedData[b*8 +: 8] = wrKeep[b] ? wrData[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrAddr] <= maskedData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr    <= '0;
      storedLen <= '0;
    end else begin
      if (ctl.wrClear)   wrAddr <= '0;
      else if (ctl.wrEn) wrAddr <= wrAddr + ADDR_W'(1);
      if (ctl.lenLatch)  storedLen <= {1'b0, wrAddr} + CNT_W'(ctl.wrEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdAddr <= '0;
    else if (ctl.rdClear) rdAddr <= '0;
    else if (ctl.rdStep) rdAddr <= rdAtEnd ? '0 : rdAddr + ADDR_W'(1);
  end

  assign rdData  = mem[rdAddr];
  assign wrFull  = (wrAddr == ADDR_W'(DEPTH - 1));
  assign wrEmpty = (wrAddr == '0);
  assign rdAtEnd = ({1'b0, rdAddr} == storedLen - CNT_W'(1));

  // R8: reads only step inside a non-empty stored buffer
  assert_step_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdStep |-> (storedLen != '0 && {1'b0, rdAddr} < storedLen));

  // R3: a latched length is between one beat and the full depth
  assert_len_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lenLatch |=> (storedLen != '0 && storedLen <= CNT_W'(DEPTH)));

endmodule

// File: rtl/tx_offload_fsm.sv
module tx_offload_fsm
  import tx_offload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       initReq,
  input  logic       syncPulse,
  input  logic       swStart,
  input  logic [1:0] syncMode,
  input  logic       oneshot,
  input  logic       bypass,
  input  logic       outReady,
  input  logic       wrFull,
  input  logic       wrEmpty,
  input  logic       rdAtEnd,
  output storeCtl_t  ctl,
  output logic       inReady,
  output logic       outValid,
  output ctrlState_t state,
  output logic       swPending
);

  ctrlState_t nextState;
  logic isAuto, isHw, isSw;
  logic accept, endBuf, earlySync, armedGo, playStep, playDone, swConsume;

  assign isAuto    = (syncMode == MODE_AUTO);
  assign isHw      = (syncMode == MODE_HW);
  assign isSw      = syncMode[1];
  assign inReady   = (state == ST_FILL) && !bypass;
  assign outValid  = (state == ST_PLAY) && !bypass;
  assign accept    = inValid && inReady;
  assign endBuf    = accept && (inLast || wrFull);
  assign earlySync = isHw && syncPulse && (accept || !wrEmpty);
  assign armedGo   = isAuto || (isHw && syncPulse) || (isSw && swPending);
  assign playStep  = outValid && outReady;
  assign playDone  = playStep && rdAtEnd && oneshot;
  assign swConsume = (state == ST_ARMED) && isSw && swPending && !bypass;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (initReq) begin
          nextState   = ST_FILL;
          ctl.wrClear = 1'b1;
        end
      end
      ST_FILL: begin
        ctl.wrEn = accept;
        if (endBuf || earlySync) begin
          ctl.lenLatch = 1'b1;
          if (isAuto || earlySync) begin
            nextState   = ST_PLAY;
            ctl.rdClear = 1'b1;
          end else begin
            nextState = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (armedGo) begin
          nextState   = ST_PLAY;
          ctl.rdClear = 1'b1;
        end
      end
      ST_PLAY: begin
        ctl.rdStep = playStep;
        if (playDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (bypass) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || bypass) swPending <= 1'b0;
    else if (swStart)    swPending <= 1'b1;
    else if (swConsume)  swPending <= 1'b0;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !initReq) |=> state == ST_IDLE);

  assert_sw_consume_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swConsume && !swStart) |=> (!swPending && state == ST_PLAY));

  assert_cyclic_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (playStep && rdAtEnd && !oneshot && !bypass) |=> (state == ST_PLAY));

  assert_oneshot_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    playDone |=> state == ST_IDLE);

  assert_init_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLAY && !bypass && !(playStep && rdAtEnd && oneshot)) |=> state == ST_PLAY);

  assert_bypass_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    bypass |=> (state == ST_IDLE && !swPending));

endmodule

// File: rtl/tx_offload_ctrl.sv
module tx_offload_ctrl
  import tx_offload_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W/8-1:0] inKeep,
  input  logic                inLast,
  input  logic                initReq,
  input  logic                syncPulse,
  input  logic                swStart,
  input  logic [1:0]          syncMode,
  input  logic                oneshot,
  input  logic                bypass,
  output logic                outValid,
  input  logic                outReady,
  output logic [DATA_W-1:0]   outData,
  output logic [1:0]          stateCode,
  output logic                swPending
);

  storeCtl_t         ctl;
  ctrlState_t        state;
  logic              fsmInReady, fsmOutValid;
  logic              wrFull, wrEmpty, rdAtEnd;
  logic [DATA_W-1:0] rdData;

  tx_offload_fsm u_fsm (
    .clk, .rstN, .inValid, .inLast, .initReq, .syncPulse, .swStart,
    .syncMode, .oneshot, .bypass, .outReady, .wrFull, .wrEmpty, .rdAtEnd,
    .ctl, .inReady(fsmInReady), .outValid(fsmOutValid), .state, .swPending
  );

  tx_offload_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk, .rstN, .ctl, .wrData(inData), .wrKeep(inKeep),
    .rdData, .wrFull, .wrEmpty, .rdAtEnd
  );

  assign inReady   = bypass ? outReady : fsmInReady;
  assign outValid  = bypass ? inValid  : fsmOutValid;
  assign outData   = bypass ? inData   : rdData;
  assign stateCode = state;

  // R12: a stalled playback beat holds
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !bypass) |=> (bypass || (outValid && $stable(outData))));

endmodule

// File: tb/tx_offload_ctrl_test.sv
`timescale 1ns/1ps
module tx_offload_ctrl_test;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, initReq = 1'b0, syncPulse = 1'b0;
  logic swStart = 1'b0, oneshot = 1'b0, bypass = 1'b0, outReady = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic [3:0] inKeep = 4'hF;
  logic [1:0] syncMode = 2'd0;
  logic inReady, outValid, swPending;
  logic [DATA_W-1:0] outData;
  logic [1:0] stateCode;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] expBeat [DEPTH];

  tx_offload_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk, .rstN, .inValid, .inReady, .inData, .inKeep, .inLast, .initReq,
    .syncPulse, .swStart, .syncMode, .oneshot, .bypass, .outValid, .outReady,
    .outData, .stateCode, .swPending
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] maskBeat(logic [DATA_W-1:0] d, logic [3:0] k);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = k[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkEq(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic pulseInit();
    initReq = 1'b1;
    tick();
    initReq = 1'b0;
    checkEq("R2 fill state", 32'(stateCode), 32'd1);
  endtask

  // mode 0 automatic, 1 hardware, 2 software
  task automatic doBuffer(input int mode, input int n, input logic [3:0] lastKeep,
                          input int reads, input bit useLast);
    int rem;
    syncMode = 2'(mode);
    oneshot  = 1'b0;
    pulseInit();
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = $urandom;
      inLast  = useLast && (i == n - 1);
      inKeep  = (useLast && i == n - 1) ? lastKeep : 4'hF;
      expBeat[i] = maskBeat(inData, inKeep);
      checkEq("R2 ready in fill", 32'(inReady), 32'd1);
      tick();
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    inKeep  = 4'hF;
    if (mode == 0) begin
      checkEq("R4 auto play", 32'(stateCode), 32'd3);
    end else begin
      checkEq("R5 armed", 32'(stateCode), 32'd2);
      tick();
      tick();
      checkEq("R5 waits for trigger", 32'(stateCode), 32'd2);
      if (mode == 1) begin
        syncPulse = 1'b1;
        tick();
        syncPulse = 1'b0;
      end else begin
        swStart = 1'b1;
        tick();
        swStart = 1'b0;
        checkEq("R7 request pending", 32'(swPending), 32'd1);
        checkEq("R7 still armed", 32'(stateCode), 32'd2);
        tick();
        checkEq("R7 request consumed", 32'(swPending), 32'd0);
      end
      checkEq("R5 R7 play", 32'(stateCode), 32'd3);
    end
    outReady = 1'b1;
    for (int k = 0; k < reads; k++) begin
      if (k == 1) begin
        outReady = 1'b0;
        for (int s = 0; s < 2; s++) begin
          tick();
          checkEq("R12 stall valid", 32'(outValid), 32'd1);
          checkEq("R12 stall data", outData, expBeat[1 % n]);
        end
        outReady = 1'b1;
      end
      if (k == 2) initReq = 1'b1;
      checkEq("R3 R8 beat", outData, expBeat[k % n]);
      checkEq("R8 valid", 32'(outValid), 32'd1);
      tick();
      initReq = 1'b0;
      if (k == 2) checkEq("R10 init ignored", 32'(stateCode), 32'd3);
    end
    oneshot = 1'b1;
    rem = n - (reads % n);
    for (int k = 0; k < rem; k++) begin
      checkEq("R9 final pass beat", outData, expBeat[(reads + k) % n]);
      tick();
    end
    checkEq("R9 back to idle", 32'(stateCode), 32'd0);
    checkEq("R9 output idle", 32'(outValid), 32'd0);
    outReady = 1'b0;
    oneshot  = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick();
    tick();
    rstN = 1'b1;
    checkEq("R1 state", 32'(stateCode), 32'd0);
    checkEq("R1 inReady", 32'(inReady), 32'd0);
    checkEq("R1 outValid", 32'(outValid), 32'd0);
    checkEq("R1 swPending", 32'(swPending), 32'd0);

    inValid = 1'b1;
    tick();
    checkEq("R2 idle refuses", 32'(inReady), 32'd0);
    checkEq("R2 idle holds", 32'(stateCode), 32'd0);
    inValid = 1'b0;

    doBuffer(0, 5, 4'b0011, 12, 1'b1);
    doBuffer(1, 4, 4'b1000, 6, 1'b1);
    doBuffer(2, 3, 4'b0101, 4, 1'b1);
    doBuffer(0, 1, 4'b0001, 3, 1'b1);
    doBuffer(0, DEPTH, 4'hF, DEPTH + 2, 1'b0);

    for (int r = 0; r < 10; r++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      doBuffer(int'($urandom % 3), n, 4'(($urandom % 15) + 1),
               int'($urandom % (2 * n + 3)), 1'b1);
    end

    // R6: early hardware sync
    syncMode = 2'd1;
    oneshot  = 1'b1;
    pulseInit();
    syncPulse = 1'b1;
    tick();
    syncPulse = 1'b0;
    checkEq("R6 empty sync ignored", 32'(stateCode), 32'd1);
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1;
      inData  = $urandom;
      inKeep  = 4'hF;
      expBeat[i] = inData;
      syncPulse = (i == 2);
      tick();
    end
    syncPulse = 1'b0;
    checkEq("R6 early play", 32'(stateCode), 32'd3);
    checkEq("R6 remainder refused", 32'(inReady), 32'd0);
    inValid  = 1'b0;
    outReady = 1'b1;
    for (int k = 0; k < 3; k++) begin
      checkEq("R6 short buffer beat", outData, expBeat[k]);
      tick();
    end
    checkEq("R6 short buffer ends", 32'(stateCode), 32'd0);
    outReady = 1'b0;
    oneshot  = 1'b0;

    // R11: bypass
    swStart = 1'b1;
    tick();
    swStart = 1'b0;
    checkEq("R7 pending set in idle", 32'(swPending), 32'd1);
    syncMode = 2'd0;
    pulseInit();
    bypass = 1'b1;
    tick();
    checkEq("R11 idle", 32'(stateCode), 32'd0);
    checkEq("R11 pending cleared", 32'(swPending), 32'd0);
    inValid = 1'b1;
    inData  = 32'hA5C3_0F96;
    inKeep  = 4'h1;
    outReady = 1'b0;
    #1;
    checkEq("R11 valid through", 32'(outValid), 32'd1);
    checkEq("R11 data through", outData, 32'hA5C3_0F96);
    checkEq("R11 ready low", 32'(inReady), 32'd0);
    outReady = 1'b1;
    #1;
    checkEq("R11 ready through", 32'(inReady), 32'd1);
    bypass  = 1'b0;
    inValid = 1'b0;
    outReady = 1'b0;
    inKeep  = 4'hF;
    tick();
    checkEq("R11 idle after bypass", 32'(stateCode), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule